// File: doc/BRIEF.md
# Ultra DMA Burst Transfer Engine

This block is the device-side half of a double-edge Ultra DMA burst on a 16-bit parallel bus. It decides, cycle by cycle, whether the burst meaning of the shared control pins is in force. That is true only when a burst mode is enabled, a transfer command is pending, the device is requesting and the host is acknowledging. Whenever any of these is missing, the pins keep their ordinary roles.

In a data-in burst (device to host) the block is the sender. It takes a word from its system-side source port, puts it on the bus, lets it settle for a configurable number of clock cycles, then flips its strobe. Every flip, rising or falling, marks one word. The host paces the block with a ready line and can ask it to halt. In a data-out burst (host to device) the block is the receiver. It samples the bus whenever the host's strobe changes level and queues each word in a small buffer. The system side drains that buffer through a pop-style read port. The block lowers its own ready line early, so that a word already in flight always has room.

All control pins are modelled at their logical level (1 = asserted). Inversion at the pads lies outside this block.

Top module: `udma_burst_engine`

## Requirements
- R1: A burst is qualified only while `mode_sel_i`, a command (`cmd_in_i` or `cmd_out_i`), `dev_req_o` and `host_ack_i` are all 1. Outside a qualified burst (or the stop wind-down of R6), `bus_oe_o`, `dev_pace_o` and `dev_rstb_o` stay 0, no source word is taken, and host strobe changes store nothing.
- R2: `dev_req_o` is 0 whenever `mode_sel_i` is 0. With the mode enabled and a command pending it is 1, except during the stop wind-down of R6.
- R3: In a data-in burst, the source words appear on `bus_data_o` in the order they were taken. Each change of `dev_rstb_o` (either direction) delivers exactly one word.
- R4: `dev_rstb_o` changes only after `bus_data_o` has held the word for at least SETUP_CYC clock cycles. With `host_pace_i` held at 1 the gap is exactly SETUP_CYC cycles.
- R5: While `host_pace_i` is 0, `dev_rstb_o` holds its level. No word is lost or repeated across a pause.
- R6: When `host_halt_i` is 1 during a data-in burst, the word being settled still gets its strobe change. After that, `dev_req_o` drops and no further word is taken. `bus_oe_o` stays 1 until `host_ack_i` falls. `dev_req_o` returns once `host_ack_i` is 0 and the command is still pending.
- R7: When `host_ack_i` is 0, `bus_oe_o` is 0 in the same cycle and `dev_rstb_o` is 0 from the next cycle on.
- R8: In a data-out burst, each level change of `host_wstb_i` stores the current `bus_data_i` word. Words leave on `rx_data_o` in arrival order, one per cycle in which `rx_valid_o` and `rx_pop_i` are both 1.
- R9: `dev_pace_o` is 0 once the buffer holds RX_DEPTH-1 words. A word that arrives after that is still stored, up to RX_DEPTH words.
- R10: `host_halt_i` has no effect outside a qualified data-in burst.
- R11: After reset, `dev_req_o`, `bus_oe_o`, `dev_rstb_o`, `dev_pace_o` and `rx_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 1 | Ultra DMA mode enabled |
| cmd_in_i | input | 1 | Data-in (device to host) command pending |
| cmd_out_i | input | 1 | Data-out (host to device) command pending |
| dev_req_o | output | 1 | Device DMA request |
| host_ack_i | input | 1 | Host DMA acknowledge |
| host_halt_i | input | 1 | Host request to end the burst |
| host_pace_i | input | 1 | Host ready to receive (data-in) |
| host_wstb_i | input | 1 | Host data strobe (data-out), both edges |
| bus_data_i | input | 16 | Bus data from the host |
| bus_data_o | output | 16 | Bus data to the host |
| bus_oe_o | output | 1 | Device drives the data bus |
| dev_rstb_o | output | 1 | Device data strobe (data-in), both edges |
| dev_pace_o | output | 1 | Device ready to receive (data-out) |
| burst_o | output | 1 | Burst meaning of the pins in force |
| tx_data_i | input | 16 | Word offered for a data-in burst |
| tx_valid_i | input | 1 | `tx_data_i` is valid |
| tx_take_o | output | 1 | Word taken this cycle |
| rx_data_o | output | 16 | Oldest received word |
| rx_valid_o | output | 1 | Receive buffer not empty |
| rx_pop_i | input | 1 | Remove the oldest received word |

## Verification
Data-in traffic is run three ways: with pacing and supply held constant, which pins the strobe gap to exactly SETUP_CYC; with random host pauses and random source gaps, which separates correct holding from lost or repeated words; and with a halt raised while a word is settling, which shows whether that word is finished or dropped. Data-out traffic is run first with no draining, so that the ready line must fall at RX_DEPTH-1 and one word in flight must still land, and then with random draining and random host gaps to check ordering. Unqualified combinations (mode off, acknowledge with no command, halt outside a burst) show whether the pins ever take their burst meaning too early.

// File: rtl/udma_pkg.sv
package udma_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic {
    TX_IDLE,
    TX_SETTLE
  } tx_state_e;
endpackage

// File: rtl/udma_tx_sender.sv
module udma_tx_sender
  import udma_pkg::*;
#(
  parameter int unsigned DW        = WORD_W,
  parameter int unsigned SETUP_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_i,
  input  logic          burst_i,
  input  logic          halt_i,
  input  logic          pace_i,
  input  logic [DW-1:0] wd_i,
  input  logic          wvalid_i,
  output logic          wtake_o,
  output logic [DW-1:0] data_o,
  output logic          strobe_o,
  output logic          req_ok_o,
  output logic          stopping_o
);
  localparam int unsigned CW = (SETUP_CYC < 2) ? 1 : $clog2(SETUP_CYC + 1);

  tx_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] data_q;
  logic          strobe_q, strobe_d;
  logic          stop_q, stop_d;
  logic          fire;

  // next-state logic
  always_comb begin
    wtake_o  = (state_q == TX_IDLE) && burst_i && !stop_q && !halt_i &&
               pace_i && wvalid_i;
    fire     = (state_q == TX_SETTLE) && (cnt_q == '0) && pace_i && ack_i;
    state_d  = state_q;
    cnt_d    = cnt_q;
    case (state_q)
      TX_IDLE: begin
        if (wtake_o) begin
          state_d = TX_SETTLE;
          cnt_d   = CW'(SETUP_CYC - 1);
        end
      end
      TX_SETTLE: begin
        if (!ack_i || fire) begin
          state_d = TX_IDLE;
        end else if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = TX_IDLE;
    endcase
    strobe_d = !ack_i ? 1'b0 : (fire ? ~strobe_q : strobe_q);
    stop_d   = !ack_i ? 1'b0 : (stop_q | (burst_i & halt_i));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TX_IDLE;
      cnt_q    <= '0;
      data_q   <= '0;
      strobe_q <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      strobe_q <= strobe_d;
      stop_q   <= stop_d;
      if (wtake_o) begin
        data_q <= wd_i;
      end
    end
  end

  assign data_o     = data_q;
  assign strobe_o   = strobe_q;
  assign req_ok_o   = !(stop_q && (state_q == TX_IDLE));
  assign stopping_o = stop_q;
endmodule

// File: rtl/udma_rx_capture.sv
module udma_rx_capture
  import udma_pkg::*;
#(
  parameter int unsigned DW    = WORD_W,
  parameter int unsigned DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       burst_i,
  input  logic                       wstb_i,
  input  logic [DW-1:0]              wdata_i,
  output logic                       pace_o,
  output logic [DW-1:0]              rd_data_o,
  output logic                       rd_valid_o,
  input  logic                       rd_pop_i,
  output logic [$clog2(DEPTH+1)-1:0] level_o
);
  localparam int unsigned AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          stb_q;
  logic          push, pop;

  always_comb begin
    push  = burst_i && (wstb_i != stb_q) && (cnt_q != CW'(DEPTH));
    pop   = rd_pop_i && (cnt_q != '0);
    wp_d  = wp_q;
    rp_d  = rp_q;
    if (push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      stb_q <= wstb_i;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wp_q] <= wdata_i;
    end
  end

  assign rd_data_o  = mem[rp_q];
  assign rd_valid_o = (cnt_q != '0);
  assign pace_o     = burst_i && (cnt_q < CW'(DEPTH - 1));
  assign level_o    = cnt_q;
endmodule

// File: rtl/udma_burst_engine.sv
module udma_burst_engine
  import udma_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned RX_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel_i,
  input  logic              cmd_in_i,
  input  logic              cmd_out_i,
  output logic              dev_req_o,
  input  logic              host_ack_i,
  input  logic              host_halt_i,
  input  logic              host_pace_i,
  input  logic              host_wstb_i,
  input  logic [WORD_W-1:0] bus_data_i,
  output logic [WORD_W-1:0] bus_data_o,
  output logic              bus_oe_o,
  output logic              dev_rstb_o,
  output logic              dev_pace_o,
  output logic              burst_o,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_take_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_pop_i
);
  localparam int unsigned LW = $clog2(RX_DEPTH + 1);

  logic              rd_sel, wr_sel;
  logic              burst_rd, burst_wr;
  logic              req_ok, stopping;
  logic [WORD_W-1:0] tx_word;
  logic [LW-1:0]     rx_level;

  // burst qualification: data-in has priority if both commands are raised
  assign rd_sel    = mode_sel_i && cmd_in_i;
  assign wr_sel    = mode_sel_i && cmd_out_i && !cmd_in_i;
  assign dev_req_o = (rd_sel && req_ok) || wr_sel;
  assign burst_rd  = rd_sel && dev_req_o && host_ack_i;
  assign burst_wr  = wr_sel && host_ack_i;
  assign burst_o   = burst_rd || burst_wr;

  udma_tx_sender #(
    .DW       (WORD_W),
    .SETUP_CYC(SETUP_CYC)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_i     (host_ack_i),
    .burst_i   (burst_rd),
    .halt_i    (host_halt_i),
    .pace_i    (host_pace_i),
    .wd_i      (tx_data_i),
    .wvalid_i  (tx_valid_i),
    .wtake_o   (tx_take_o),
    .data_o    (tx_word),
    .strobe_o  (dev_rstb_o),
    .req_ok_o  (req_ok),
    .stopping_o(stopping)
  );

  udma_rx_capture #(
    .DW   (WORD_W),
    .DEPTH(RX_DEPTH)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .burst_i   (burst_wr),
    .wstb_i    (host_wstb_i),
    .wdata_i   (bus_data_i),
    .pace_o    (dev_pace_o),
    .rd_data_o (rx_data_o),
    .rd_valid_o(rx_valid_o),
    .rd_pop_i  (rx_pop_i),
    .level_o   (rx_level)
  );

  // bus drive stays on through the stop wind-down until acknowledge falls
  assign bus_oe_o   = rd_sel && host_ack_i && (dev_req_o || stopping);
  assign bus_data_o = bus_oe_o ? tx_word : '0;
endmodule

// File: rtl/udma_burst_chk.sv
module udma_burst_chk #(
  parameter int unsigned RX_DEPTH = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          mode_sel_i,
  input logic                          dev_req_o,
  input logic                          host_ack_i,
  input logic                          host_pace_i,
  input logic [15:0]                   bus_data_o,
  input logic                          bus_oe_o,
  input logic                          dev_rstb_o,
  input logic                          dev_pace_o,
  input logic [$clog2(RX_DEPTH+1)-1:0] rx_level
);
  // R1
  oe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> (host_ack_i && mode_sel_i));

  // R2
  req_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sel_i |-> !dev_req_o);

  // R4
  data_held_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack_i && !$stable(dev_rstb_o)) |-> $stable(bus_data_o));

  // R5
  pause_holds_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack_i && !host_pace_i) |=> (!host_ack_i || $stable(dev_rstb_o)));

  // R7
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ack_i |=> !dev_rstb_o);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= ($clog2(RX_DEPTH+1))'(RX_DEPTH));

  // R9
  early_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= ($clog2(RX_DEPTH+1))'(RX_DEPTH - 1)) |-> !dev_pace_o);
endmodule

bind udma_burst_engine udma_burst_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_sel_i (mode_sel_i),
  .dev_req_o  (dev_req_o),
  .host_ack_i (host_ack_i),
  .host_pace_i(host_pace_i),
  .bus_data_o (bus_data_o),
  .bus_oe_o   (bus_oe_o),
  .dev_rstb_o (dev_rstb_o),
  .dev_pace_o (dev_pace_o),
  .rx_level   (rx_level)
);

// File: tb/udma_burst_engine_test.sv
`timescale 1ns/1ps
module udma_burst_engine_test;
  localparam int SETUP = 2;
  localparam int DEPTH = 4;
  localparam int N_RD  = 40;
  localparam int N_WR  = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_sel, cmd_in, cmd_out, ack, halt, pace, wstb;
  logic [15:0] bdat_i;
  logic        src_en, rx_pop, cons_en;
  logic        dev_req, oe, rstb, dpace, burst, take, rx_valid;
  logic [15:0] bdat_o, rx_data;
  logic [15:0] tx_data;
  logic        tx_valid;

  int checks = 0;
  int fails  = 0;
  int src_idx = 0;
  int rd_idx = 0;
  int rx_idx = 0;
  int wi = 0;
  int stable_cnt = 0;
  bit exact = 0;
  bit done = 0;
  logic        prev_stb = 1'b0;
  logic        prev_pace = 1'b0;
  logic [15:0] prev_data = '0;

  always #5 clk = ~clk;

  function automatic logic [15:0] r_of(int i);
    return 16'(i * 16'h03b1 + 16'h05a5);
  endfunction

  function automatic logic [15:0] w_of(int i);
    return 16'(i * 16'h2f0d + 16'h0c31);
  endfunction

  assign tx_data  = r_of(src_idx);
  assign tx_valid = src_en && (src_idx < 1000);

  udma_burst_engine #(.SETUP_CYC(SETUP), .RX_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel), .cmd_in_i(cmd_in),
    .cmd_out_i(cmd_out), .dev_req_o(dev_req), .host_ack_i(ack),
    .host_halt_i(halt), .host_pace_i(pace), .host_wstb_i(wstb),
    .bus_data_i(bdat_i), .bus_data_o(bdat_o), .bus_oe_o(oe),
    .dev_rstb_o(rstb), .dev_pace_o(dpace), .burst_o(burst),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_take_o(take),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_pop_i(rx_pop)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) if (take) src_idx <= src_idx + 1;

  // host receiver for data-in bursts
  always @(negedge clk) begin
    if (rst_n) begin
      if (bdat_o != prev_data) stable_cnt = 0;
      else stable_cnt++;
      if (ack && rstb != prev_stb) begin
        check(bdat_o == r_of(rd_idx), "R3", "word on strobe edge", bdat_o, r_of(rd_idx));
        if (exact) check(stable_cnt == SETUP, "R4", "exact settle cycles", stable_cnt, SETUP);
        else       check(stable_cnt >= SETUP, "R4", "min settle cycles", stable_cnt, SETUP);
        check(prev_pace == 1'b1, "R5", "edge while paused", prev_pace, 1);
        rd_idx++;
      end
      prev_stb  = rstb;
      prev_data = bdat_o;
      prev_pace = pace;
    end
  end

  // system-side consumer for data-out bursts
  always @(negedge clk) begin
    logic p;
    p = cons_en && ($urandom % 2 == 0);
    if (p && rx_valid) begin
      check(rx_data == w_of(rx_idx), "R8", "received word order", rx_data, w_of(rx_idx));
      rx_idx++;
    end
    rx_pop = p;
  end

  task automatic send_raw();
    bdat_i = w_of(wi);
    wi++;
    step();
    wstb = ~wstb;
    step();
  endtask

  task automatic send_word();
    for (int g = 0; g < 200 && !dpace; g++) step();
    repeat ($urandom % 3) step();
    for (int g = 0; g < 200 && !dpace; g++) step();
    send_raw();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int s0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; mode_sel = 0; cmd_in = 0; cmd_out = 0; ack = 0; halt = 0;
    pace = 0; wstb = 0; bdat_i = '0; src_en = 0; cons_en = 0; rx_pop = 0;
    repeat (3) step();
    @(negedge clk);
    // R11 reset state
    check(dev_req == 0, "R11", "req after reset", dev_req, 0);
    check(oe == 0, "R11", "oe after reset", oe, 0);
    check(rstb == 0 && dpace == 0, "R11", "strobe/pace after reset", {rstb, dpace}, 0);
    check(rx_valid == 0, "R11", "rx_valid after reset", rx_valid, 0);
    step();
    rst_n = 1'b1;

    // R1/R2: mode off, command and ack present
    cmd_in = 1; ack = 1; src_en = 1; pace = 1;
    repeat (8) step();
    @(negedge clk);
    check(dev_req == 0, "R2", "req with mode off", dev_req, 0);
    check(oe == 0 && rstb == 0, "R1", "drive/strobe with mode off", {oe, rstb}, 0);
    check(src_idx == 0, "R1", "words taken unqualified", src_idx, 0);

    // R1: ack without command, host strobe toggles
    step();
    mode_sel = 1; cmd_in = 0;
    for (int k = 0; k < 4; k++) begin
      bdat_i = 16'($urandom);
      step();
      wstb = ~wstb;
      step();
    end
    @(negedge clk);
    check(rx_valid == 0, "R1", "capture without burst", rx_valid, 0);
    check(dpace == 0 && dev_req == 0, "R1", "pace/req without command", {dpace, dev_req}, 0);

    // R10: halt outside a burst
    step();
    ack = 0; halt = 1;
    repeat (3) step();
    halt = 0; cmd_in = 1;
    step();
    @(negedge clk);
    check(dev_req == 1, "R10", "req after halt outside burst", dev_req, 1);

    // data-in, constant pacing (R3, R4 exact)
    step();
    exact = 1; ack = 1; pace = 1; src_en = 1;
    for (int g = 0; g < 500 && rd_idx < 10; g++) step();
    exact = 0;
    // random pauses and gaps (R3, R4, R5)
    for (int g = 0; g < 4000 && rd_idx < N_RD; g++) begin
      pace   = ($urandom % 4) != 0;
      src_en = ($urandom % 3) != 0;
      step();
    end
    check(rd_idx >= N_RD, "R3", "words delivered", rd_idx, N_RD);

    // R6: halt while a word is settling
    pace = 1; src_en = 1;
    s0 = src_idx;
    for (int g = 0; g < 100 && src_idx == s0; g++) step();
    halt = 1;
    repeat (6) step();
    @(negedge clk);
    check(dev_req == 0, "R6", "req after halt", dev_req, 0);
    check(oe == 1, "R6", "drive held until ack falls", oe, 1);
    check(rd_idx == src_idx, "R6", "settling word finished", rd_idx, src_idx);
    step();
    ack = 0;
    step();
    @(negedge clk);
    // R7
    check(oe == 0, "R7", "drive after ack low", oe, 0);
    check(rstb == 0, "R7", "strobe after ack low", rstb, 0);
    step();
    halt = 0;
    step();
    @(negedge clk);
    check(dev_req == 1, "R6", "req returns after ack low", dev_req, 1);

    // data-out burst
    step();
    cmd_in = 0; cmd_out = 1; src_en = 0; ack = 1;
    step();
    for (int k = 0; k < DEPTH - 1; k++) send_word();
    @(negedge clk);
    check(dpace == 0, "R9", "ready at DEPTH-1 words", dpace, 0);
    step();
    send_raw();
    cons_en = 1;
    for (int g = 0; g < 500 && rx_idx < DEPTH; g++) step();
    check(rx_idx == DEPTH, "R9", "in-flight word kept", rx_idx, DEPTH);
    while (wi < N_WR) begin
      cons_en = ($urandom % 4) != 0;
      send_word();
    end
    cons_en = 1;
    for (int g = 0; g < 2000 && rx_idx < N_WR; g++) step();
    check(rx_idx == N_WR, "R8", "all words received", rx_idx, N_WR);
    ack = 0;
    step();
    summary();
  end
endmodule